// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of an SDRAM interface and walks a freshly powered memory from reset to a usable state. For a programmable pause it keeps clock enable and every data-mask bit high and issues only no-operation commands. It then closes both banks with a precharge-all and issues a run of auto refresh commands. Last, it loads the mode register with a word supplied on an input port. Each command is followed by NOP cycles, so the spacing to the next command equals a configured cycle count.

When the mode register load has settled, `init_done` rises and stays high. From that point the block only drives NOP, so that a normal access scheduler can take over. A low level on the synchronous reset at any time aborts the sequence. The sequence then starts again from the pause.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: While reset is low, and during the pause, the pins carry NOP (chip select 0, row strobe 1, column strobe 1, write enable 1). Clock enable is 1, every mask bit is 1, address and bank are all zero, and `init_done` is 0.
- R2: The pause covers the first PAUSE_CYC cycles after reset is released, counting the cycle before the first clock edge. The first command is precharge-all, driven in cycle PAUSE_CYC-1 with the pins 0,0,1,0 and address bit 10 set (address value 0x400).
- R3: The first auto refresh comes exactly TRP_CYC cycles after the precharge, with NOP in between.
- R4: Auto refresh (pins 0,0,0,1 with clock enable high) is issued the clamped refresh count of times. Consecutive refreshes are TRC_CYC cycles apart, with NOP between them.
- R5: A mode register set (pins 0,0,0,0) comes TRC_CYC cycles after the last refresh. Its address carries `mode_word` and its bank is zero.
- R6: NOP follows the mode register set, and `init_done` rises exactly TMRD_CYC cycles after it.
- R7: Once high, `init_done` stays high until reset. From then on only NOP is driven, all mask bits are 0, and clock enable stays 1.
- R8: Reset taken in any cycle, including one in which a command would issue, forces NOP in the next cycle. The full sequence then restarts from the pause.
- R9: Every non-NOP command lasts exactly one cycle and is followed by NOP.
- R10: A refresh count parameter below eight yields eight refreshes. A count above eight is honoured as given. Spacing parameters below two are raised to two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset; restarts the sequence |
| mode_word | input | ADDR_W | Value placed on the address pins during the mode register set |
| sd_cke | output | 1 | Clock enable to the memory |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_dqm | output | DQM_W | Data mask bits, high until initialization ends |
| sd_ba | output | BA_W | Bank select, always zero here |
| sd_addr | output | ADDR_W | Address pins |
| init_done | output | 1 | High once the memory is ready |

## Verification
A reset request and the expiry of a step interval can fall in the same cycle. In that cycle the sequencer would otherwise move to its next command. The bench provokes the collision by pulling reset low on the edge where a refresh is due. It judges the result by requiring NOP with `init_done` low in the following cycle, and then a complete, correctly timed sequence after release. A second instance with different timing and a refresh count above eight runs alongside. It shows that the command spacing follows the parameters.

// File: rtl/sdram_init_pkg.sv
// Package: shared step encoding and command pin patterns for the power-up
// sequencer. Assumes a four-wire command bus (cs, ras, cas, we, all active low).
package sdram_init_pkg;

    typedef enum logic [2:0] {
        STEP_PAUSE = 3'd0,
        STEP_PRECH = 3'd1,
        STEP_REFR  = 3'd2,
        STEP_MODE  = 3'd3,
        STEP_DONE  = 3'd4
    } step_t;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } cmd_pins_t;

    localparam cmd_pins_t PINS_NOP   = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam cmd_pins_t PINS_PRECH = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
    localparam cmd_pins_t PINS_REFR  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
    localparam cmd_pins_t PINS_MODE  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

    // Address bit that selects "all banks" on a precharge
    localparam int ALL_BANKS_BIT = 10;

endpackage

// File: rtl/seq_countdown.sv
// Module: loadable down counter with a zero flag.
// Assumes the owner never requests a decrement while the count is already zero;
// a load always wins over a decrement.
module seq_countdown #(
    parameter int             W       = 8,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);

    logic [W-1:0] count_q;

    // Count register: reset value, load, or step down by one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= RST_VAL;
        end else if (load) begin
            count_q <= load_val;
        end else if (dec && (count_q != '0)) begin
            count_q <= count_q - 1'b1;
        end
    end

    // Zero flag seen by the sequencer
    always_comb zero = (count_q == '0);

    // The owner must not ask for a step below zero (interval bookkeeping, R3/R4)
    assert_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |-> !zero);

endmodule

// File: rtl/seq_cmd_drive.sv
// Module: turns the current step and its first-cycle strobe into pin levels.
// Assumes the strobe is high only in the first cycle of a command step; all
// other cycles drive NOP. Pure decode from flops, so the pins change only at edges.
module seq_cmd_drive
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int BA_W   = 1,
    parameter int DQM_W  = 2
) (
    input  step_t             step,
    input  logic              strobe,
    input  logic [ADDR_W-1:0] mode_word,
    output cmd_pins_t         pins,
    output logic              cke,
    output logic [DQM_W-1:0]  dqm,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr
);

    localparam logic [ADDR_W-1:0] ADDR_ALL = ADDR_W'(1) << ALL_BANKS_BIT;

    // Command pins and address for the active step
    always_comb begin
        pins = PINS_NOP;
        addr = '0;
        if (strobe) begin
            unique case (step)
                STEP_PRECH: begin
                    pins = PINS_PRECH;
                    addr = ADDR_ALL;
                end
                STEP_REFR: pins = PINS_REFR;
                STEP_MODE: begin
                    pins = PINS_MODE;
                    addr = mode_word;
                end
                default: pins = PINS_NOP;
            endcase
        end
    end

    // Static controls: clock always enabled, masks held until ready, bank zero
    always_comb begin
        cke = 1'b1;
        dqm = (step == STEP_DONE) ? '0 : '1;
        ba  = '0;
    end

endmodule

// File: rtl/sdram_pwrup_seq.sv
// Module: SDRAM power-up sequencer top. Runs pause, precharge-all, N auto
// refreshes and a mode register set, then raises init_done.
// Assumes: the clock runs from reset; every spacing parameter counts cycles from
// one command to the next; mode_word is stable while the sequence runs.
module sdram_pwrup_seq
    import sdram_init_pkg::*;
#(
    parameter int PAUSE_CYC = 20000,
    parameter int TRP_CYC   = 3,
    parameter int TRC_CYC   = 7,
    parameter int TMRD_CYC  = 2,
    parameter int REF_COUNT = 8,
    parameter int ADDR_W    = 11,
    parameter int BA_W      = 1,
    parameter int DQM_W     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] mode_word,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [DQM_W-1:0]  sd_dqm,
    output logic [BA_W-1:0]   sd_ba,
    output logic [ADDR_W-1:0] sd_addr,
    output logic              init_done
);

    // Clamped timing values
    localparam int PAUSE_C  = (PAUSE_CYC < 1) ? 1 : PAUSE_CYC;
    localparam int TRP_C    = (TRP_CYC   < 2) ? 2 : TRP_CYC;
    localparam int TRC_C    = (TRC_CYC   < 2) ? 2 : TRC_CYC;
    localparam int TMRD_C   = (TMRD_CYC  < 2) ? 2 : TMRD_CYC;
    localparam int NREF     = (REF_COUNT < 8) ? 8 : REF_COUNT;
    localparam int MAX_A    = (PAUSE_C > TRP_C) ? PAUSE_C : TRP_C;
    localparam int MAX_B    = (TRC_C > TMRD_C) ? TRC_C : TMRD_C;
    localparam int WAIT_MAX = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int WAIT_W   = $clog2(WAIT_MAX + 1);
    localparam int REF_W    = $clog2(NREF + 1);

    localparam logic [WAIT_W-1:0] LD_PAUSE = WAIT_W'(PAUSE_C - 1);
    localparam logic [WAIT_W-1:0] LD_TRP   = WAIT_W'(TRP_C - 1);
    localparam logic [WAIT_W-1:0] LD_TRC   = WAIT_W'(TRC_C - 1);
    localparam logic [WAIT_W-1:0] LD_TMRD  = WAIT_W'(TMRD_C - 1);
    localparam logic [REF_W-1:0]  LD_REFS  = REF_W'(NREF - 1);

    step_t              step_q, step_d;
    logic               strobe_q;
    logic               advance;
    logic               wait_zero, refs_zero;
    logic [WAIT_W-1:0]  wait_ld_val;
    logic               refs_load, refs_dec;
    cmd_pins_t          pins;

    // Interval timer shared by every step
    seq_countdown #(.W(WAIT_W), .RST_VAL(LD_PAUSE)) i_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (advance),
        .load_val (wait_ld_val),
        .dec      (!wait_zero),
        .zero     (wait_zero)
    );

    // Remaining-refresh counter
    seq_countdown #(.W(REF_W), .RST_VAL('0)) i_refs (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (refs_load),
        .load_val (LD_REFS),
        .dec      (refs_dec),
        .zero     (refs_zero)
    );

    // Step ends when its interval has elapsed
    always_comb advance = wait_zero && (step_q != STEP_DONE);

    // Next step and the interval that comes with it
    always_comb begin
        step_d      = step_q;
        wait_ld_val = '0;
        unique case (step_q)
            STEP_PAUSE: begin
                step_d      = STEP_PRECH;
                wait_ld_val = LD_TRP;
            end
            STEP_PRECH: begin
                step_d      = STEP_REFR;
                wait_ld_val = LD_TRC;
            end
            STEP_REFR: begin
                if (refs_zero) begin
                    step_d      = STEP_MODE;
                    wait_ld_val = LD_TMRD;
                end else begin
                    step_d      = STEP_REFR;
                    wait_ld_val = LD_TRC;
                end
            end
            STEP_MODE: step_d = STEP_DONE;
            default:   step_d = STEP_DONE;
        endcase
    end

    // Refresh counter control: armed on leaving precharge, stepped per refresh
    always_comb begin
        refs_load = advance && (step_q == STEP_PRECH);
        refs_dec  = advance && (step_q == STEP_REFR) && !refs_zero;
    end

    // Step register and first-cycle strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q   <= STEP_PAUSE;
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= advance && (step_d != STEP_DONE);
            if (advance) begin
                step_q <= step_d;
            end
        end
    end

    // Pin decode
    seq_cmd_drive #(.ADDR_W(ADDR_W), .BA_W(BA_W), .DQM_W(DQM_W)) i_drive (
        .step      (step_q),
        .strobe    (strobe_q),
        .mode_word (mode_word),
        .pins      (pins),
        .cke       (sd_cke),
        .dqm       (sd_dqm),
        .ba        (sd_ba),
        .addr      (sd_addr)
    );

    // Port mapping of the command bus and ready flag
    always_comb begin
        sd_cs_n   = pins.cs_n;
        sd_ras_n  = pins.ras_n;
        sd_cas_n  = pins.cas_n;
        sd_we_n   = pins.we_n;
        init_done = (step_q == STEP_DONE);
    end

    // Checker support: refreshes seen on the pins since reset
    logic [REF_W:0] refs_seen_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            refs_seen_q <= '0;
        end else if ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == PINS_REFR) begin
            refs_seen_q <= refs_seen_q + 1'b1;
        end
    end

    assert_pause_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (step_q == STEP_PAUSE) |-> ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == PINS_NOP)
                                   && sd_cke && (&sd_dqm) && !init_done);

    assert_prech_all_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == PINS_PRECH) |-> sd_addr[ALL_BANKS_BIT]);

    assert_ref_total_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == PINS_MODE) |-> (refs_seen_q == (REF_W+1)'(NREF)));

    assert_one_cycle_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} != PINS_NOP)
        |=> ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == PINS_NOP));

    assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == PINS_NOP) && (sd_dqm == '0));

endmodule

// File: tb/test_sdram_pwrup_seq.sv
module test_sdram_pwrup_seq;

    localparam int CLK_PERIOD = 10;

    // Instance A: refresh count below eight, clamped
    localparam int A_P = 20, A_TRP = 3, A_TRC = 5, A_TMRD = 2, A_REQ = 4;
    localparam int A_N = (A_REQ < 8) ? 8 : A_REQ;
    // Instance B: refresh count above eight, different spacing
    localparam int B_P = 12, B_TRP = 2, B_TRC = 3, B_TMRD = 3, B_N = 10;
    localparam int RUN_LEN = 80;

    localparam logic [10:0] VEC_MODE [4] = '{11'h032, 11'h7FF, 11'h000, 11'h2A5};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] mode_a = '0, mode_b = '0;

    logic        a_cke, a_cs_n, a_ras_n, a_cas_n, a_we_n, a_done, a_ba;
    logic [1:0]  a_dqm;
    logic [10:0] a_addr;
    logic        b_cke, b_cs_n, b_ras_n, b_cas_n, b_we_n, b_done, b_ba;
    logic [1:0]  b_dqm;
    logic [10:0] b_addr;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_pwrup_seq #(.PAUSE_CYC(A_P), .TRP_CYC(A_TRP), .TRC_CYC(A_TRC),
                      .TMRD_CYC(A_TMRD), .REF_COUNT(A_REQ)) i_sdram_pwrup_seq (
        .clk(clk), .rst_n(rst_n), .mode_word(mode_a),
        .sd_cke(a_cke), .sd_cs_n(a_cs_n), .sd_ras_n(a_ras_n), .sd_cas_n(a_cas_n),
        .sd_we_n(a_we_n), .sd_dqm(a_dqm), .sd_ba(a_ba), .sd_addr(a_addr),
        .init_done(a_done));

    sdram_pwrup_seq #(.PAUSE_CYC(B_P), .TRP_CYC(B_TRP), .TRC_CYC(B_TRC),
                      .TMRD_CYC(B_TMRD), .REF_COUNT(B_N)) i_sdram_pwrup_seq_b (
        .clk(clk), .rst_n(rst_n), .mode_word(mode_b),
        .sd_cke(b_cke), .sd_cs_n(b_cs_n), .sd_ras_n(b_ras_n), .sd_cas_n(b_cas_n),
        .sd_we_n(b_we_n), .sd_dqm(b_dqm), .sd_ba(b_ba), .sd_addr(b_addr),
        .init_done(b_done));

    // Expected command code per cycle: 0 NOP, 1 precharge, 2 refresh, 3 mode set
    function automatic int exp_code(int i, int p, int trp, int trc, int n);
        int pre = p - 1;
        int r0  = pre + trp;
        int mrs = r0 + n * trc;
        if (i == pre) return 1;
        if (i >= r0 && i < mrs && ((i - r0) % trc == 0)) return 2;
        if (i == mrs) return 3;
        return 0;
    endfunction

    function automatic logic [3:0] code_pins(int c);
        case (c)
            1: return 4'b0010;
            2: return 4'b0001;
            3: return 4'b0000;
            default: return 4'b0111;
        endcase
    endfunction

    // Requirement tag for a cycle of instance A
    function automatic string phase_tag(int i);
        int pre = A_P - 1;
        int r0  = pre + A_TRP;
        int mrs = r0 + A_N * A_TRC;
        if (i < pre) return "R1";
        if (i == pre) return "R2";
        if (i < r0) return (i == pre + 1) ? "R9" : "R3";
        if (i < mrs) return "R4";
        if (i == mrs) return "R5";
        if (i < mrs + A_TMRD) return "R6";
        return "R7";
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Reset for a few cycles and check the quiet reset state (R1)
    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check({a_cke, a_dqm, a_done, a_cs_n, a_ras_n, a_cas_n, a_we_n, a_ba, a_addr}
              == {1'b1, 2'b11, 1'b0, 4'b0111, 1'b0, 11'h000}, "R1 reset",
              {12'h0, a_cke, a_dqm, a_done, a_cs_n, a_ras_n, a_cas_n, a_we_n, a_ba, a_addr},
              {12'h0, 1'b1, 2'b11, 1'b0, 4'b0111, 1'b0, 11'h000});
    endtask

    // Release reset and compare instance A each cycle up to 'last'; track B
    task automatic run_seq(input logic [10:0] mw, input int last);
        int b_refs = 0;
        int b_mrs  = -1;
        int b_rdy  = -1;
        int a_mrs  = A_P - 1 + A_TRP + A_N * A_TRC;
        logic [19:0] got, want;
        mode_a = mw;
        mode_b = ~mw;
        rst_n  = 1'b1;
        for (int i = 0; i <= last; i++) begin
            int c;
            @(negedge clk);
            c    = exp_code(i, A_P, A_TRP, A_TRC, A_N);
            got  = {a_cke, a_dqm, a_done, a_cs_n, a_ras_n, a_cas_n, a_we_n, a_ba, a_addr};
            want = {1'b1, (i >= a_mrs + A_TMRD) ? 2'b00 : 2'b11, i >= a_mrs + A_TMRD,
                    code_pins(c), 1'b0,
                    (c == 1) ? 11'h400 : (c == 3) ? mw : 11'h000};
            check(got == want, phase_tag(i), {12'h0, got}, {12'h0, want});
            if ({b_cs_n, b_ras_n, b_cas_n, b_we_n} == 4'b0001) b_refs++;
            if ({b_cs_n, b_ras_n, b_cas_n, b_we_n} == 4'b0000) begin
                b_mrs = i;
                check(b_addr == ~mw && b_ba == 1'b0, "R5 second instance word",
                      {21'h0, b_addr}, {21'h0, ~mw});
            end
            if (b_done && b_rdy < 0) b_rdy = i;
        end
        if (last >= RUN_LEN) begin
            check(b_refs == B_N, "R10 refresh count above eight", b_refs, B_N);
            check(b_mrs == B_P - 1 + B_TRP + B_N * B_TRC, "R4 refresh spacing",
                  b_mrs, B_P - 1 + B_TRP + B_N * B_TRC);
            check(b_rdy == b_mrs + B_TMRD, "R6 ready delay", b_rdy, b_mrs + B_TMRD);
        end
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        // Table walk: full sequence for each mode word
        for (int v = 0; v < 4; v++) begin
            apply_reset();
            run_seq(VEC_MODE[v], RUN_LEN);
        end

        // R8: reset lands on the edge where the second refresh is due (cycle 27)
        apply_reset();
        run_seq(11'h155, A_P - 1 + A_TRP + A_TRC - 1);
        rst_n = 1'b0;
        @(negedge clk);
        check({a_cs_n, a_ras_n, a_cas_n, a_we_n, a_done} == 5'b01110,
              "R8 reset beats refresh", {27'h0, a_cs_n, a_ras_n, a_cas_n, a_we_n, a_done},
              {27'h0, 5'b01110});
        @(negedge clk);
        run_seq(11'h0AA, RUN_LEN);

        // R8: reset taken after completion drops ready and restarts the pause
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(a_done == 1'b0 && a_dqm == 2'b11, "R8 reset after ready",
              {29'h0, a_done, a_dqm}, {29'h0, 3'b011});
        run_seq(11'h3C3, RUN_LEN);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule